// File: doc/BRIEF.md
# Parallel-Port Frame Readout Engine

This block hands one sampled frame at a time to a host across an enhanced parallel-port data-read handshake. A capture stage pulses `frame_ready` once per frame, about every 25 us, with five 14-bit samples on `frame_data`. The block stores the frame in a hold register and raises `irq` so the host starts reading. The host then fetches exactly ten bytes. For each byte it pulls the active-low `host_strobe_n` low and later releases it.

The strobe is asynchronous to the block clock and passes through two synchronizer flops. When the block sees the strobe fall, it latches the next byte, drives it onto `data_out`, and raises `host_wait` and `data_oe` together. When it sees the strobe rise, it drops both and moves to the next byte. A byte position counter runs from 0 to 9 and then wraps. The hold register is only copied into the readout register when byte 0 of a frame is fetched, so a capture arriving during a burst cannot change the byte on the bus.

A capture that arrives while a frame is still waiting to be read or is part way through readout sets a sticky `overrun` flag. The burst then restarts at byte 0 with the newer frame. A host that releases the strobe early, before the wait acknowledge, still moves the position by exactly one byte.

Top module: `epp_frame_reader`

## Requirements
- R1: In the clock cycle after a `frame_ready` pulse is sampled, `irq` is 1.
- R2: `irq` returns to 0 when the first strobe of a frame is acknowledged, in the same cycle `host_wait` rises, unless another frame arrives in that cycle.
- R3: The strobe is synchronized by two flops. `host_wait` rises on the third rising clock edge after `host_strobe_n` goes low. The byte position advances on the third rising clock edge after `host_strobe_n` goes high. Neither changes earlier.
- R4: The bytes follow a fixed layout. Sample k is held in `frame_data[14k+13:14k]`. Byte 2k is bits 7:0 of sample k. Byte 2k+1 carries bits 13:8 of sample k in bits 5:0, with bits 7:6 set to zero.
- R5: A frame is exactly 10 bytes. `byte_pos` counts 0 to 9 and returns to 0 after the tenth byte completes.
- R6: `host_wait` and `data_oe` are 1 from the acknowledge until the synchronized strobe release. At all other times both are 0 and `data_out` is 0.
- R7: A strobe held low for only one clock, and released before the acknowledge, advances `byte_pos` by exactly one with no lost or repeated byte.
- R8: The readout register loads from the hold register only when byte 0 is fetched. A capture during a strobe, or a change on `frame_data` after capture, leaves the byte on the bus unchanged.
- R9: A capture while the hold register is unread, `byte_pos` is nonzero, or a strobe cycle is in progress sets `overrun` to 1. `overrun` stays 1 until reset. `irq` is set again, and the next byte read is byte 0 of the newest frame.
- R10: After reset, `irq`, `host_wait`, `data_oe`, `overrun`, `byte_pos` and `data_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_ready | input | 1 | One-cycle pulse: a new frame is valid on frame_data |
| frame_data | input | 70 | Five 14-bit samples, sample k at bits 14k+13:14k |
| host_strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| host_wait | output | 1 | Handshake acknowledge to the host |
| data_out | output | 8 | Byte driven to the port data lines |
| data_oe | output | 1 | Output enable for the data lines |
| irq | output | 1 | Frame-available interrupt request |
| overrun | output | 1 | Sticky flag: a frame was replaced before it was fully read |
| byte_pos | output | 4 | Index of the next byte within the frame |

## Verification
A strobe edge reaches the outputs on the third rising clock edge after the edge is driven: two edges for the synchronizer and one for the handshake register. A `frame_ready` pulse shows on `irq` and `overrun` one edge after it is sampled. The bench drives every input on a falling clock edge and samples outputs on falling edges. It checks `host_wait` after two falling edges, where it must still be low, and again after three, where it must be high. The byte position is checked the same way after each release. Short one-clock strobes, a capture in the middle of a strobe, and a back-to-back capture are each checked at the first sample point after their effect is due.

// File: rtl/epp_rd_pkg.sv
package epp_rd_pkg;
  localparam int NUM_SAMP = 5;
  localparam int SAMP_W   = 14;
  localparam int BYTE_W   = 8;
  localparam int FRAME_W  = NUM_SAMP * SAMP_W;
  localparam int BYTES    = NUM_SAMP * 2;
  localparam int POS_W    = $clog2(BYTES);
endpackage

// File: rtl/epp_rd_sync.sv
module epp_rd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n_i,
  output logic stb_low_o,
  output logic fall_o,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= strobe_n_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign stb_low_o = ~s2_q;
  assign fall_o    = s3_q & ~s2_q;
  assign rise_o    = ~s3_q & s2_q;

  // R3
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/epp_rd_store.sv
module epp_rd_store #(
  parameter int NUM_SAMP = 5,
  parameter int SAMP_W   = 14,
  parameter int BYTE_W   = 8,
  parameter int POS_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_i,
  input  logic [NUM_SAMP*SAMP_W-1:0]   cap_data_i,
  input  logic                         fall_i,
  input  logic                         rise_i,
  input  logic                         ack_i,
  input  logic [POS_W-1:0]             pos_i,
  output logic                         pend_full_o,
  output logic                         take_o,
  output logic [BYTE_W-1:0]            byte_o
);
  localparam int FW = NUM_SAMP * SAMP_W;
  localparam int XW = 2 * BYTE_W;

  logic [FW-1:0]     pend_q, pend_n;
  logic [FW-1:0]     act_q, act_n;
  logic              full_q, full_n;
  logic [BYTE_W-1:0] byte_q, byte_n;
  logic [FW-1:0]     src;
  logic              take;

  function automatic logic [BYTE_W-1:0] pick(input logic [FW-1:0] fr,
                                             input logic [POS_W-1:0] p);
    logic [SAMP_W-1:0] s;
    logic [XW-1:0]     ext;
    s   = fr[(int'(p) / 2) * SAMP_W +: SAMP_W];
    ext = XW'(s);
    return p[0] ? ext[XW-1:BYTE_W] : ext[BYTE_W-1:0];
  endfunction

  assign take = fall_i && (pos_i == '0) && full_q;
  assign src  = take ? pend_q : act_q;

  always_comb begin
    pend_n = pend_q;
    full_n = full_q;
    act_n  = act_q;
    byte_n = byte_q;
    if (take) begin
      act_n  = pend_q;
      full_n = 1'b0;
    end
    if (cap_i) begin
      pend_n = cap_data_i;
      full_n = 1'b1;
    end
    if (fall_i) byte_n = pick(src, pos_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      full_q <= 1'b0;
      byte_q <= '0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
      full_q <= full_n;
      byte_q <= byte_n;
    end
  end

  assign pend_full_o = full_q;
  assign take_o      = take;
  assign byte_o      = byte_q;

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !rise_i && !fall_i) |=> $stable(byte_q));
  // R8
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cap_i) |=> !full_q);
endmodule

// File: rtl/epp_rd_ctrl.sv
module epp_rd_ctrl #(
  parameter int BYTES = 10,
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic             stb_low_i,
  input  logic             pend_full_i,
  input  logic             take_i,
  output logic             ack_o,
  output logic [POS_W-1:0] pos_o,
  output logic             irq_o,
  output logic             ovr_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(BYTES - 1);

  logic             ack_q, ack_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic             irq_q, irq_n;
  logic             ovr_q, ovr_n;
  logic             skip_q, skip_n;
  logic             busy;

  assign busy = pend_full_i || (pos_q != '0) || ack_q || stb_low_i;

  always_comb begin
    ack_n  = ack_q;
    pos_n  = pos_q;
    irq_n  = irq_q;
    ovr_n  = ovr_q;
    skip_n = skip_q;
    if (fall_i)      ack_n = 1'b1;
    else if (rise_i) ack_n = 1'b0;
    if (cap_i) begin
      pos_n  = '0;
      skip_n = (ack_q || stb_low_i) && !rise_i;
      irq_n  = 1'b1;
      if (busy) ovr_n = 1'b1;
    end else begin
      if (take_i) irq_n = 1'b0;
      if (rise_i) begin
        if (skip_q) skip_n = 1'b0;
        else        pos_n  = (pos_q == LAST) ? '0 : pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      pos_q  <= '0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      ack_q  <= ack_n;
      pos_q  <= pos_n;
      irq_q  <= irq_n;
      ovr_q  <= ovr_n;
      skip_q <= skip_n;
    end
  end

  assign ack_o = ack_q;
  assign pos_o = pos_q;
  assign irq_o = irq_q;
  assign ovr_o = ovr_q;

  // R1
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> irq_q);
  // R2
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !cap_i) |=> !irq_q);
  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> !ack_q);
  // R3
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_i |=> ack_q);
  // R5
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST);
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (pos_q == '0));
endmodule

// File: rtl/epp_frame_reader.sv
module epp_frame_reader
  import epp_rd_pkg::*;
#(
  parameter int N_SAMP = NUM_SAMP,
  parameter int S_W    = SAMP_W,
  parameter int B_W    = BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_ready,
  input  logic [N_SAMP*S_W-1:0]   frame_data,
  input  logic                    host_strobe_n,
  output logic                    host_wait,
  output logic [B_W-1:0]          data_out,
  output logic                    data_oe,
  output logic                    irq,
  output logic                    overrun,
  output logic [$clog2(2*N_SAMP)-1:0] byte_pos
);
  localparam int NB = 2 * N_SAMP;
  localparam int PW = $clog2(NB);

  logic          stb_low, fall, rise;
  logic          pend_full, take, ack;
  logic [PW-1:0] pos;
  logic [B_W-1:0] byte_val;

  epp_rd_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_n_i (host_strobe_n),
    .stb_low_o  (stb_low),
    .fall_o     (fall),
    .rise_o     (rise)
  );

  epp_rd_store #(
    .NUM_SAMP (N_SAMP),
    .SAMP_W   (S_W),
    .BYTE_W   (B_W),
    .POS_W    (PW)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_i       (frame_ready),
    .cap_data_i  (frame_data),
    .fall_i      (fall),
    .rise_i      (rise),
    .ack_i       (ack),
    .pos_i       (pos),
    .pend_full_o (pend_full),
    .take_o      (take),
    .byte_o      (byte_val)
  );

  epp_rd_ctrl #(
    .BYTES (NB),
    .POS_W (PW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_i       (frame_ready),
    .fall_i      (fall),
    .rise_i      (rise),
    .stb_low_i   (stb_low),
    .pend_full_i (pend_full),
    .take_i      (take),
    .ack_o       (ack),
    .pos_o       (pos),
    .irq_o       (irq),
    .ovr_o       (overrun)
  );

  assign host_wait = ack;
  assign data_oe   = ack;
  assign data_out  = ack ? byte_val : '0;
  assign byte_pos  = pos;

  // R6
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));
endmodule

// File: tb/epp_frame_reader_bench.sv
module epp_frame_reader_bench;
  import epp_rd_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               frame_ready;
  logic [FRAME_W-1:0] frame_data;
  logic               host_strobe_n;
  logic               host_wait;
  logic [7:0]         data_out;
  logic               data_oe;
  logic               irq;
  logic               overrun;
  logic [POS_W-1:0]   byte_pos;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  epp_frame_reader u_epp_frame_reader (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_ready   (frame_ready),
    .frame_data    (frame_data),
    .host_strobe_n (host_strobe_n),
    .host_wait     (host_wait),
    .data_out      (data_out),
    .data_oe       (data_oe),
    .irq           (irq),
    .overrun       (overrun),
    .byte_pos      (byte_pos)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [FRAME_W-1:0] fr, input int idx);
    int v;
    v = int'((fr >> (SAMP_W * (idx / 2))) & FRAME_W'(16383));
    return (idx % 2 == 1) ? 8'(v / 256) : 8'(v % 256);
  endfunction

  function automatic logic [FRAME_W-1:0] make_frame(input int seed);
    logic [FRAME_W-1:0] fr;
    fr = '0;
    for (int s = 0; s < NUM_SAMP; s++) begin
      int v;
      case (seed)
        0:       v = 16383;
        1:       v = 0;
        2:       v = (s % 2 == 1) ? 'h1555 : 'h2AAA;
        default: v = (seed * 1103 + s * 2731 + 7) % 16384;
      endcase
      fr = fr | (FRAME_W'(v) << (SAMP_W * s));
    end
    return fr;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic capture(input logic [FRAME_W-1:0] fr);
    frame_data  = fr;
    frame_ready = 1'b1;
    @(negedge clk);
    frame_ready = 1'b0;
    frame_data  = ~fr;
  endtask

  // one full byte cycle with latency checks
  task automatic read_byte(input logic [FRAME_W-1:0] fr, input int idx, input bit first);
    host_strobe_n = 1'b0;
    idle(2);
    chk("R3 wait before third edge", int'(host_wait), 0);
    idle(1);
    chk("R6 wait during strobe", int'(host_wait), 1);
    chk("R6 oe during strobe", int'(data_oe), 1);
    chk("R4 byte value", int'(data_out), int'(exp_byte(fr, idx)));
    if (first) chk("R2 irq cleared", int'(irq), 0);
    idle(2);
    host_strobe_n = 1'b1;
    idle(2);
    chk("R3 position held before third edge", int'(byte_pos), idx);
    idle(1);
    chk("R5 position advance", int'(byte_pos), (idx + 1) % BYTES);
    chk("R6 bus idle after release", int'(data_out) + int'(data_oe) + int'(host_wait), 0);
    idle(1);
  endtask

  task automatic apply_reset;
    rst_n         = 1'b0;
    frame_ready   = 1'b0;
    frame_data    = '0;
    host_strobe_n = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R10 reset state",
        int'(irq) + int'(host_wait) + int'(data_oe) + int'(overrun) + int'(byte_pos) + int'(data_out), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [FRAME_W-1:0] fa, fb;
    apply_reset();

    // clean frames over several data patterns
    for (int f = 0; f < 7; f++) begin
      fa = make_frame(f);
      capture(fa);
      chk("R1 irq after capture", int'(irq), 1);
      for (int b = 0; b < BYTES; b++) read_byte(fa, b, b == 0);
      chk("R5 wrap to zero", int'(byte_pos), 0);
      chk("R9 no overrun on clean frame", int'(overrun), 0);
    end

    // early-released strobes
    fa = make_frame(11);
    capture(fa);
    for (int b = 0; b < 5; b++) begin
      host_strobe_n = 1'b0;
      idle(1);
      host_strobe_n = 1'b1;
      idle(5);
      chk("R7 single advance on short strobe", int'(byte_pos), b + 1);
      chk("R7 bus idle after short strobe", int'(host_wait), 0);
    end
    for (int b = 5; b < BYTES; b++) read_byte(fa, b, 1'b0);
    chk("R7 frame complete", int'(byte_pos), 0);

    // capture in the middle of a strobe
    fa = make_frame(12);
    fb = make_frame(13);
    capture(fa);
    for (int b = 0; b < 3; b++) read_byte(fa, b, b == 0);
    host_strobe_n = 1'b0;
    idle(3);
    capture(fb);
    chk("R8 bus unchanged by capture", int'(data_out), int'(exp_byte(fa, 3)));
    chk("R9 overrun set", int'(overrun), 1);
    chk("R9 irq set again", int'(irq), 1);
    host_strobe_n = 1'b1;
    idle(4);
    chk("R9 restart at byte zero", int'(byte_pos), 0);
    for (int b = 0; b < BYTES; b++) read_byte(fb, b, b == 0);
    chk("R9 overrun sticky", int'(overrun), 1);

    // back-to-back captures with no read between
    apply_reset();
    fa = make_frame(14);
    fb = make_frame(15);
    capture(fa);
    chk("R9 no overrun on first capture", int'(overrun), 0);
    capture(fb);
    chk("R9 overrun on unread frame", int'(overrun), 1);
    for (int b = 0; b < BYTES; b++) read_byte(fb, b, b == 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule